// File: doc/BRIEF.md
# Next-PC Generation Unit

This unit holds the program counter of a 32-bit instruction stream and works out, every cycle, the address the counter takes next. Each instruction is four bytes. A two-bit source select picks one of four kinds of flow: straight-line fetch, a conditional branch relative to the following instruction, an absolute jump placed inside the current 256 MB region, or a jump through a register value. For a conditional branch, the unit settles the outcome itself. It combines a zero-test flag with a one-bit branch kind that means "branch if zero" or "branch if nonzero".

The counter loads the computed address on each rising clock edge. A stall input freezes it, and a synchronous active-high reset forces it to a start address set by a parameter. The incremented address is also an output, so a jump-and-link can write it to the return-address register. Instruction decode and the register file sit outside this block. They supply the select, the branch kind, the offset and target fields, the register operand and the zero flag.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes `RESET_VEC` (default 32'h0000_0100) after that edge, whatever `stall` is.
- R2: With `rst` low and `stall` high at a rising edge, `pc` keeps its value across that edge.
- R3: With `src_sel` = 0 (sequential), `next_pc` equals `pc` + 4, wrapping modulo 2^32.
- R4: `link_pc` always equals `pc` + 4 modulo 2^32, for every source select.
- R5: With `src_sel` = 1 and the branch taken, `next_pc` equals `pc` + 4 plus the 16-bit `br_offset` sign-extended and shifted left by two, modulo 2^32. This reaches both extremes, offset 16'h8000 and offset 16'h7FFF.
- R6: With `src_sel` = 1, `br_kind` = 0 takes the branch when `zero_flag` is 1, and `br_kind` = 1 takes it when `zero_flag` is 0. A branch that is not taken gives `next_pc` = `pc` + 4.
- R7: With `src_sel` = 2, `next_pc` is bits 31:28 of (`pc` + 4), then the 26-bit `jmp_target`, then two zero bits. The region bits come from the incremented address, not from `pc`.
- R8: With `src_sel` = 3, `next_pc` equals `reg_operand` unchanged.
- R9: With `rst` and `stall` both low at a rising edge, `pc` takes the value `next_pc` had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to `RESET_VEC` |
| stall | input | 1 | Holds the counter when high |
| src_sel | input | 2 | 0 sequential, 1 conditional branch, 2 absolute jump, 3 register jump |
| br_kind | input | 1 | 0 branch on zero, 1 branch on nonzero |
| zero_flag | input | 1 | High when the tested register is zero |
| br_offset | input | 16 | Signed branch displacement in words |
| jmp_target | input | 26 | Word index inside the current 256 MB region |
| reg_operand | input | 32 | Register value for an indirect jump |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded at the next unstalled edge |
| link_pc | output | 32 | Counter plus four, used as the return address |

## Verification
The bench aims at the places where an adder or a splice most easily goes wrong. It tests an absolute jump from the last word of one region: a design that takes the region bits from the current counter lands 256 MB too low. It tests backward branches and both offset extremes: an offset that is zero-extended or left unscaled sends the branch far off or only a few bytes away. Sequential flow and a taken branch both run past the top of the address space, so a carry that escapes the 32-bit wrap shows up there. Swapped branch polarity, a stall that leaks one update, and a stall that overrides reset each show up as a wrong counter value one edge after the stimulus.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN        = 32;
    localparam int OFF_W       = 16;
    localparam int TGT_W       = 26;
    localparam int WORD_SHIFT  = 2;
    localparam int REGION_W    = XLEN - TGT_W - WORD_SHIFT;
    localparam int OFF_EXT_W   = XLEN - OFF_W - WORD_SHIFT;
    localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(1 << WORD_SHIFT);

    typedef logic [XLEN-1:0]  addr_t;
    typedef logic [OFF_W-1:0] boff_t;
    typedef logic [TGT_W-1:0] jtgt_t;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JABS   = 2'd2,
        NPC_JREG   = 2'd3
    } npc_src_e;

    typedef enum logic {
        BR_ON_ZERO    = 1'b0,
        BR_ON_NONZERO = 1'b1
    } br_cond_e;

    // Candidate addresses produced from the current counter.
    typedef struct packed {
        addr_t link;
        addr_t branch;
        addr_t jabs;
    } cand_t;

    // Offset in words -> signed byte displacement.
    function automatic addr_t scale_offset(input boff_t off);
        return {{OFF_EXT_W{off[OFF_W-1]}}, off, {WORD_SHIFT{1'b0}}};
    endfunction

    // Region bits of the incremented address joined with the word index.
    function automatic addr_t splice_target(input addr_t seq, input jtgt_t tgt);
        return {seq[XLEN-1 -: REGION_W], tgt, {WORD_SHIFT{1'b0}}};
    endfunction

    function automatic logic resolve_taken(input br_cond_e cond, input logic zero);
        logic taken;
        unique case (cond)
            BR_ON_ZERO:    taken = zero;
            BR_ON_NONZERO: taken = ~zero;
            default:       taken = 1'b0;
        endcase
        return taken;
    endfunction

endpackage

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  addr_t pc_i,
    input  boff_t off_i,
    input  jtgt_t tgt_i,
    output cand_t cand_o
);

    addr_t seq_addr;

    always_comb begin
        seq_addr      = pc_i + INSTR_BYTES;
        cand_o.link   = seq_addr;
        cand_o.branch = seq_addr + scale_offset(off_i);
        cand_o.jabs   = splice_target(seq_addr, tgt_i);
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  npc_src_e src_i,
    input  br_cond_e cond_i,
    input  logic     zero_i,
    input  cand_t    cand_i,
    input  addr_t    reg_i,
    output addr_t    next_o
);

    logic taken;

    always_comb begin
        taken = resolve_taken(cond_i, zero_i);
        unique case (src_i)
            NPC_SEQ:    next_o = cand_i.link;
            NPC_BRANCH: next_o = taken ? cand_i.branch : cand_i.link;
            NPC_JABS:   next_o = cand_i.jabs;
            NPC_JREG:   next_o = reg_i;
            default:    next_o = cand_i.link;
        endcase
    end

    assert_seq_falls_through_R3: assert property (@(posedge clk) disable iff (rst)
        (src_i == NPC_SEQ) |-> (next_o == cand_i.link));

    // Zero flag matching the kind bit means "not taken" for either kind.
    assert_untaken_branch_R6: assert property (@(posedge clk) disable iff (rst)
        ((src_i == NPC_BRANCH) && (zero_i == (cond_i == BR_ON_NONZERO)))
            |-> (next_o == cand_i.link));

    assert_jump_stays_in_region_R7: assert property (@(posedge clk) disable iff (rst)
        (src_i == NPC_JABS)
            |-> ((next_o[XLEN-1 -: REGION_W] == cand_i.link[XLEN-1 -: REGION_W])
                 && (next_o[WORD_SHIFT-1:0] == '0)));

    assert_reg_jump_passthrough_R8: assert property (@(posedge clk) disable iff (rst)
        (src_i == NPC_JREG) |-> (next_o == reg_i));

endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg
    import npc_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'h0000_0100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  stall_i,
    input  addr_t next_i,
    output addr_t pc_o
);

    always_ff @(posedge clk) begin
        if (rst)
            pc_o <= RESET_VEC;
        else if (!stall_i)
            pc_o <= next_i;
    end

    assert_reset_vector_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_o == RESET_VEC));

    assert_stall_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !$past(rst)) |=> (pc_o == $past(pc_o)));

    assert_advance_R9: assert property (@(posedge clk) disable iff (rst)
        !stall_i |=> (pc_o == $past(next_i)));

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stall,
    input  logic [1:0]  src_sel,
    input  logic        br_kind,
    input  logic        zero_flag,
    input  logic [15:0] br_offset,
    input  logic [25:0] jmp_target,
    input  logic [31:0] reg_operand,
    output logic [31:0] pc,
    output logic [31:0] next_pc,
    output logic [31:0] link_pc
);

    cand_t cand;
    addr_t pc_q;
    addr_t next_d;

    npc_targets u_targets (
        .pc_i   (pc_q),
        .off_i  (br_offset),
        .tgt_i  (jmp_target),
        .cand_o (cand)
    );

    npc_select u_select (
        .clk    (clk),
        .rst    (rst),
        .src_i  (npc_src_e'(src_sel)),
        .cond_i (br_cond_e'(br_kind)),
        .zero_i (zero_flag),
        .cand_i (cand),
        .reg_i  (reg_operand),
        .next_o (next_d)
    );

    npc_pcreg #(.RESET_VEC(RESET_VEC)) u_pcreg (
        .clk     (clk),
        .rst     (rst),
        .stall_i (stall),
        .next_i  (next_d),
        .pc_o    (pc_q)
    );

    assign pc      = pc_q;
    assign next_pc = next_d;
    assign link_pc = cand.link;

    assert_link_is_next_word_R4: assert property (@(posedge clk) disable iff (rst)
        (link_pc - pc) == 32'd4);

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

    localparam logic [31:0] RV = 32'h0000_0100;
    localparam int NV = 13;

    typedef struct packed {
        logic [31:0] start;
        logic [1:0]  sel;
        logic        kind;
        logic        zero;
        logic [15:0] off;
        logic [25:0] tgt;
        logic [31:0] regv;
        logic [31:0] exp;
    } vec_t;

    // start, sel, kind, zero, off, tgt, reg, expected next
    localparam logic [141:0] VECS [0:NV-1] = '{
        {32'h0000_1000, 2'd0, 1'b0, 1'b0, 16'h0000, 26'h0000000, 32'h0, 32'h0000_1004},
        {32'hFFFF_FFFC, 2'd0, 1'b0, 1'b1, 16'h1234, 26'h0000000, 32'h0, 32'h0000_0000},
        {32'h0000_2000, 2'd1, 1'b0, 1'b1, 16'h0010, 26'h0000000, 32'h0, 32'h0000_2044},
        {32'h0000_2000, 2'd1, 1'b0, 1'b0, 16'h0010, 26'h0000000, 32'h0, 32'h0000_2004},
        {32'h0000_3000, 2'd1, 1'b1, 1'b0, 16'hFFFC, 26'h0000000, 32'h0, 32'h0000_2FF4},
        {32'h0000_3000, 2'd1, 1'b1, 1'b1, 16'hFFFC, 26'h0000000, 32'h0, 32'h0000_3004},
        {32'h0010_0000, 2'd1, 1'b0, 1'b1, 16'h8000, 26'h0000000, 32'h0, 32'h000E_0004},
        {32'h0010_0000, 2'd1, 1'b1, 1'b0, 16'h7FFF, 26'h0000000, 32'h0, 32'h0012_0000},
        {32'h1234_5670, 2'd2, 1'b0, 1'b0, 16'h0000, 26'h3FFFFFF, 32'h0, 32'h1FFF_FFFC},
        {32'h2FFF_FFFC, 2'd2, 1'b0, 1'b0, 16'h0000, 26'h0000010, 32'h0, 32'h3000_0040},
        {32'h0000_4000, 2'd3, 1'b0, 1'b1, 16'h0040, 26'h0000123, 32'hDEAD_BEEC, 32'hDEAD_BEEC},
        {32'hFFFF_FFF0, 2'd1, 1'b0, 1'b1, 16'h0008, 26'h0000000, 32'h0, 32'h0000_0014},
        {32'h0000_5000, 2'd2, 1'b1, 1'b1, 16'hFFFF, 26'h0000001, 32'h0, 32'h0000_0004}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [1:0]  src_sel = 2'd0;
    logic        br_kind = 1'b0;
    logic        zero_flag = 1'b0;
    logic [15:0] br_offset = '0;
    logic [25:0] jmp_target = '0;
    logic [31:0] reg_operand = '0;
    logic [31:0] pc, next_pc, link_pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    npc_unit #(.RESET_VEC(RV)) u_dut (
        .clk, .rst, .stall, .src_sel, .br_kind, .zero_flag,
        .br_offset, .jmp_target, .reg_operand,
        .pc, .next_pc, .link_pc
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One rising edge, then settle at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // Load the counter through a register jump.
    task automatic load_pc(input logic [31:0] v);
        rst = 1'b0; stall = 1'b0;
        src_sel = 2'd3; reg_operand = v;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step();
        step();
        check("R1 reset vector", pc, RV);
        check("R4 link after reset", link_pc, RV + 32'd4);

        // Vector table: R3 R5 R6 R7 R8 with R4 and R9
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            load_pc(v.start);
            src_sel = v.sel; br_kind = v.kind; zero_flag = v.zero;
            br_offset = v.off; jmp_target = v.tgt; reg_operand = v.regv;
            #1;
            check($sformatf("R3/R5/R6/R7/R8 next_pc vec %0d", i), next_pc, v.exp);
            check($sformatf("R4 link vec %0d", i), link_pc, v.start + 32'd4);
            step();
            check($sformatf("R9 pc loaded vec %0d", i), pc, v.exp);
        end

        // R2 stall holds across several edges
        load_pc(32'h0000_8000);
        src_sel = 2'd0; stall = 1'b1;
        step();
        step();
        check("R2 stall hold", pc, 32'h0000_8000);
        stall = 1'b0;
        step();
        check("R9 resume after stall", pc, 32'h0000_8004);

        // R1 reset wins over stall
        stall = 1'b1; rst = 1'b1;
        step();
        check("R1 reset over stall", pc, RV);
        rst = 1'b0; stall = 1'b0; src_sel = 2'd0;
        step();
        check("R3 sequential from reset vector", pc, RV + 32'd4);

        // R6 both kinds not taken leave counter sequential; R5 taken after
        load_pc(32'h0000_0400);
        src_sel = 2'd1; br_kind = 1'b1; zero_flag = 1'b1; br_offset = 16'h0100;
        step();
        check("R6 nez not taken", pc, 32'h0000_0404);
        zero_flag = 1'b0;
        step();
        check("R5 nez taken", pc, 32'h0000_0808);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule